// File: doc/BRIEF.md
# Configuration Space Register File

This block holds the 256-byte configuration space of one device and answers a simple configuration access port. Each request carries a 24-bit address made of a bus number (bits 23:16), a device/function number (bits 15:8) and a byte offset (bits 7:0). It also carries a length code, a write flag and right-justified write data. Requests that match the block's own bus and device/function read or update the space. Reads that do not match return all ones sized to the request, and writes that do not match are dropped.

Writes pass through a per-byte protection map chosen by the header-type parameter. An aligned full-word write to an implemented region register, or to the expansion ROM register, stores a size-masked value instead of the raw data. In bridge mode, the secondary bus number is captured from writes to the bus-number bytes. A write touching the command bytes, or a region-register write, raises a one-cycle change strobe for the address-window decoder that sits next to this block.

A small state machine records what the last accepted request was. The states are ST_IDLE, ST_RD_HIT, ST_RD_MISS and ST_WR_HIT. From any state, the next state follows the current request:
- go_read_hit: a matching read moves to ST_RD_HIT.
- go_read_miss: a non-matching read moves to ST_RD_MISS.
- go_write: a matching write moves to ST_WR_HIT.
- go_idle: no request, or a non-matching write, returns to ST_IDLE.

The read response, with rd_valid, is presented while the state is ST_RD_HIT or ST_RD_MISS. The change strobe can only be high in ST_WR_HIT.

Top module: `cfgsp_regfile`

## Requirements
- R1: After reset the space holds the following values, and every other byte is zero. Rd_valid, map_change and sec_bus are zero.
  - Bytes 0x00-0x03 hold ID_WORD, little-endian.
  - Bytes 0x08-0x0B hold CLASS_REV, little-endian.
  - Byte 0x0E holds HDR_TYPE.
  - Byte 0x3D holds INT_PIN.
  - Each implemented region register (index i < 6, size nonzero, at offset 0x10+4*i) holds its 4-bit type in bits 3:0.
- R2: A matching read (req_len 0 = byte, 1 = halfword, 2 or 3 = word) raises rd_valid in the cycle after the request. Rd_data holds byte offset+k in bits 8k+7:8k, and bits above the access length are zero.
- R3: A matching write stores write-data byte k at offset+k for each byte of the access, little-endian, wherever the protection map allows it. Any byte that would land beyond offset 0xFF is dropped.
- R4: A word read at an offset above 0xFC is served as a halfword read, and a halfword read at an offset above 0xFE is served as a byte read.
- R5: With HDR_TYPE 0x00 or 0x80, the default write path leaves these offsets unchanged: 0x00-0x03, 0x08-0x0B, 0x0E, 0x10-0x27, 0x30-0x33 and 0x3D.
- R6: With any other HDR_TYPE (bridge mode), the default write path leaves 0x00-0x03, 0x08-0x0B, 0x0E, 0x38-0x3B and 0x3D unchanged. In this mode 0x10-0x27 and 0x30-0x33 are writable.
- R7: An aligned word write to region register i (offset 0x10+4*i, i < 6) with a nonzero size stores (data AND NOT(size-1)) OR type. With size zero, the write takes the default path.
- R8: An aligned word write to offset 0x30 with a nonzero ROM size stores data AND (NOT(ROM size-1) OR 1).
- R9: A read whose bus number or device/function differs from BUS_NUM/DEVFN still raises rd_valid the next cycle. It returns 0xFF for a byte, 0xFFFF for a halfword, or 0xFFFFFFFF for a word (len 2 or 3).
- R10: A write whose bus number or device/function does not match changes no byte and raises no strobe.
- R11: In bridge mode, the secondary bus number output sec_bus is loaded in the following cases, and in no other mode does it change:
  - Any matching write at offset 0x19 loads data bits 7:0.
  - A halfword or word write at offset 0x18 loads data bits 15:8.
- R12: map_change is high for exactly the cycle after a matching write that either overlaps offsets 0x04-0x05 or takes the region path of R7/R8. It is low after all other requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Bus number [23:16], device/function [15:8], offset [7:0] |
| req_len | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_wdata | input | 32 | Right-justified write data |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read response data |
| map_change | output | 1 | One-cycle strobe: window-relevant registers written |
| sec_bus | output | 8 | Secondary bus number (bridge mode) |

## Verification
Some properties are checked on every clock:
- the identity and header-type bytes never move;
- sec_bus changes only after an accepted write;
- a response or strobe never appears without the matching request one cycle earlier;
- any read with a foreign bus number answers with an all-ones low byte.

The bench scenarios cover the rest:
- the exact masked values stored in region and ROM registers;
- the offset-dependent protection maps of the two header types, on two instances;
- the read fallbacks and dropped bytes at the top of the space;
- which halfword/word writes at 0x18/0x19 load the secondary bus number.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_HIT  = 2'd1,
        ST_RD_MISS = 2'd2,
        ST_WR_HIT  = 2'd3
    } acc_state_e;

    localparam logic [1:0] LEN_BYTE = 2'd0;
    localparam logic [1:0] LEN_HALF = 2'd1;

    // number of bytes in a requested access (2 and 3 both mean word)
    function automatic logic [2:0] len_to_bytes(input logic [1:0] len);
        case (len)
            LEN_BYTE: return 3'd1;
            LEN_HALF: return 3'd2;
            default:  return 3'd4;
        endcase
    endfunction

    // all-ones answer for a request that does not match
    function automatic logic [31:0] miss_value(input logic [1:0] len);
        case (len)
            LEN_BYTE: return 32'h0000_00FF;
            LEN_HALF: return 32'h0000_FFFF;
            default:  return 32'hFFFF_FFFF;
        endcase
    endfunction

    // default-path protection map, selected by header kind
    function automatic logic byte_writable(input logic bridge, input logic [7:0] off);
        logic ro;
        ro = (off <= 8'h03) || (off >= 8'h08 && off <= 8'h0B) ||
             (off == 8'h0E) || (off == 8'h3D);
        if (!bridge)
            ro = ro || (off >= 8'h10 && off <= 8'h27) || (off >= 8'h30 && off <= 8'h33);
        else
            ro = ro || (off >= 8'h38 && off <= 8'h3B);
        return !ro;
    endfunction

endpackage

// File: rtl/cfgsp_decode.sv
module cfgsp_decode
    import cfgsp_pkg::*;
#(
    parameter logic [7:0] BUS_NUM = 8'h00,
    parameter logic [7:0] DEVFN   = 8'h00
) (
    input  logic [23:0] addr,
    input  logic [1:0]  len,
    input  logic        write,
    output logic        hit,
    output logic [7:0]  off,
    output logic [2:0]  wr_n,
    output logic [2:0]  rd_n,
    output logic        region_sel,
    output logic [2:0]  region_idx,
    output logic        touches_cmd
);
    logic [8:0] last_byte;

    always_comb begin
        hit  = (addr[23:16] == BUS_NUM) && (addr[15:8] == DEVFN);
        off  = addr[7:0];
        wr_n = len_to_bytes(len);

        // narrow the read near the top of the space
        rd_n = wr_n;
        if (rd_n == 3'd4 && off > 8'hFC) rd_n = 3'd2;
        if (rd_n == 3'd2 && off > 8'hFE) rd_n = 3'd1;

        // aligned full-word write to a region or ROM register
        region_sel = 1'b0;
        region_idx = 3'd0;
        if (write && wr_n == 3'd4 && off[1:0] == 2'b00) begin
            if (off >= 8'h10 && off < 8'h28) begin
                region_sel = 1'b1;
                region_idx = 3'(off[7:2] - 6'd4);
            end else if (off == 8'h30) begin
                region_sel = 1'b1;
                region_idx = 3'd6;
            end
        end

        last_byte   = {1'b0, off} + {6'b0, wr_n} - 9'd1;
        touches_cmd = (off <= 8'h05) && (last_byte >= 9'd4);
    end
endmodule

// File: rtl/cfgsp_store.sv
module cfgsp_store
    import cfgsp_pkg::*;
#(
    parameter logic [7:0]       HDR_TYPE    = 8'h00,
    parameter logic [31:0]      ID_WORD     = 32'h0000_0000,
    parameter logic [31:0]      CLASS_REV   = 32'h0000_0000,
    parameter logic [7:0]       INT_PIN     = 8'h00,
    parameter int               NUM_BARS    = 6,
    parameter logic [6:0][31:0] REGION_SIZE = '0,
    parameter logic [5:0][3:0]  REGION_TYPE = '0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  off,
    input  logic [2:0]  wr_n,
    input  logic [31:0] wdata,
    input  logic        region_sel,
    input  logic [2:0]  region_idx,
    input  logic [2:0]  rd_n,
    output logic [31:0] rd_word,
    output logic        region_take,
    output logic [7:0]  sec_bus
);
    localparam int  SPACE     = 256;
    localparam int  ROM_IDX   = NUM_BARS;
    localparam logic IS_BRIDGE = !((HDR_TYPE == 8'h00) || (HDR_TYPE == 8'h80));

    logic [7:0]  mem [SPACE];
    logic [31:0] r_size;
    logic [3:0]  r_type;
    logic [31:0] r_val;
    logic [7:0]  r_base;
    logic [7:0]  sec_q;

    function automatic logic [7:0] reset_byte(input int a);
        int k;
        if (a < 4)                return ID_WORD[8*a +: 8];
        if (a >= 8 && a < 12)     return CLASS_REV[8*(a-8) +: 8];
        if (a == 14)              return HDR_TYPE;
        if (a == 61)              return INT_PIN;
        if (a >= 16 && a < 16 + 4*NUM_BARS) begin
            k = a - 16;
            if ((k % 4) == 0 && REGION_SIZE[k/4] != 32'd0)
                return {4'b0, REGION_TYPE[k/4]};
        end
        return 8'h00;
    endfunction

    // value a region write would store
    always_comb begin
        r_size = 32'd0;
        r_type = 4'd0;
        for (int r = 0; r <= ROM_IDX; r++)
            if (region_idx == 3'(r)) r_size = REGION_SIZE[r];
        for (int r = 0; r < NUM_BARS; r++)
            if (region_idx == 3'(r)) r_type = REGION_TYPE[r];
        region_take = region_sel && (r_size != 32'd0);
        if (region_idx == 3'(ROM_IDX)) begin
            r_val  = wdata & (~(r_size - 32'd1) | 32'h1);
            r_base = 8'h30;
        end else begin
            r_val  = (wdata & ~(r_size - 32'd1)) | {28'b0, r_type};
            r_base = 8'h10 + {3'b000, region_idx, 2'b00};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int a = 0; a < SPACE; a++) mem[a] <= reset_byte(a);
        end else if (wr_en) begin
            if (region_take) begin
                for (int k = 0; k < 4; k++) mem[r_base + 8'(k)] <= r_val[8*k +: 8];
            end else begin
                for (int k = 0; k < 4; k++) begin
                    if (3'(k) < wr_n && ({1'b0, off} + 9'(k)) <= 9'd255 &&
                        byte_writable(IS_BRIDGE, off + 8'(k)))
                        mem[off + 8'(k)] <= wdata[8*k +: 8];
                end
            end
        end
    end

    always_comb begin
        rd_word = 32'd0;
        for (int k = 0; k < 4; k++)
            if (3'(k) < rd_n) rd_word[8*k +: 8] = mem[off + 8'(k)];
    end

    generate
        if (IS_BRIDGE) begin : g_sec
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    sec_q <= 8'h00;
                else if (wr_en && off == 8'h19)
                    sec_q <= wdata[7:0];
                else if (wr_en && off == 8'h18 && wr_n != 3'd1)
                    sec_q <= wdata[15:8];
            end
        end else begin : g_nosec
            assign sec_q = 8'h00;
        end
    endgenerate

    assign sec_bus = sec_q;

    // R5
    id_byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(mem[0]) && $stable(mem[3]));
    // R6
    hdr_byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(mem[14]));
    // R11
    sec_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sec_q) |-> $past(wr_en));
endmodule

// File: rtl/cfgsp_regfile.sv
module cfgsp_regfile
    import cfgsp_pkg::*;
#(
    parameter logic [7:0]       BUS_NUM     = 8'h02,
    parameter logic [7:0]       DEVFN       = 8'h18,
    parameter logic [7:0]       HDR_TYPE    = 8'h00,
    parameter logic [31:0]      ID_WORD     = 32'h1234_ABCD,
    parameter logic [31:0]      CLASS_REV   = 32'h0200_0001,
    parameter logic [7:0]       INT_PIN     = 8'h01,
    parameter logic [6:0][31:0] REGION_SIZE = {32'h800, 32'h0, 32'h0, 32'h0, 32'h0, 32'h1000, 32'h100},
    parameter logic [5:0][3:0]  REGION_TYPE = {4'h0, 4'h0, 4'h0, 4'h0, 4'h8, 4'h1}
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [23:0] req_addr,
    input  logic [1:0]  req_len,
    input  logic [31:0] req_wdata,
    output logic        rd_valid,
    output logic [31:0] rd_data,
    output logic        map_change,
    output logic [7:0]  sec_bus
);
    acc_state_e  state_q, state_d;
    logic        hit, region_sel, region_take, touches_cmd;
    logic [7:0]  off;
    logic [2:0]  wr_n, rd_n, region_idx;
    logic [31:0] store_rd, rdata_q;
    logic        chg_q;

    cfgsp_decode #(.BUS_NUM(BUS_NUM), .DEVFN(DEVFN)) u_decode (
        .addr(req_addr), .len(req_len), .write(req_write),
        .hit(hit), .off(off), .wr_n(wr_n), .rd_n(rd_n),
        .region_sel(region_sel), .region_idx(region_idx), .touches_cmd(touches_cmd)
    );

    cfgsp_store #(
        .HDR_TYPE(HDR_TYPE), .ID_WORD(ID_WORD), .CLASS_REV(CLASS_REV),
        .INT_PIN(INT_PIN), .NUM_BARS(6),
        .REGION_SIZE(REGION_SIZE), .REGION_TYPE(REGION_TYPE)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(req_valid && req_write && hit),
        .off(off), .wr_n(wr_n), .wdata(req_wdata),
        .region_sel(region_sel), .region_idx(region_idx), .rd_n(rd_n),
        .rd_word(store_rd), .region_take(region_take), .sec_bus(sec_bus)
    );

    // next-state selection
    always_comb begin
        state_d = ST_IDLE;
        if (req_valid) begin
            if (!req_write)
                state_d = hit ? ST_RD_HIT : ST_RD_MISS;
            else if (hit)
                state_d = ST_WR_HIT;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // response datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= 32'd0;
            chg_q   <= 1'b0;
        end else begin
            if (req_valid && !req_write)
                rdata_q <= hit ? store_rd : miss_value(req_len);
            chg_q <= req_valid && req_write && hit && (touches_cmd || region_take);
        end
    end

    // outputs by state
    always_comb begin
        rd_valid   = 1'b0;
        rd_data    = 32'd0;
        map_change = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_RD_HIT,
            ST_RD_MISS: begin
                rd_valid = 1'b1;
                rd_data  = rdata_q;
            end
            ST_WR_HIT:  map_change = chg_q;
        endcase
    end

    // R2
    rdv_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid && !req_write));
    // R9
    miss_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr[23:16] != BUS_NUM) |=>
        (rd_valid && rd_data[7:0] == 8'hFF));
    // R12
    strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        map_change |-> $past(req_valid && req_write && hit));
    // R10
    miss_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !hit) |=> !map_change && !rd_valid);
endmodule

// File: tb/tb_cfgsp_regfile.sv
`timescale 1ns/1ps
module tb_cfgsp_regfile;
    localparam logic [7:0] BUS = 8'h02;
    localparam logic [7:0] DFN = 8'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        v0 = 1'b0, v1 = 1'b0;
    logic        wr = 1'b0;
    logic [23:0] addr = '0;
    logic [1:0]  len = '0;
    logic [31:0] wd = '0;
    logic        rv0, rv1, ch0, ch1;
    logic [31:0] rd0, rd1;
    logic [7:0]  sb0, sb1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] g_rd;
    logic        g_v, g_ch;
    logic [7:0]  g_sb;

    always #2.5 clk = ~clk;

    cfgsp_regfile dut (
        .clk(clk), .rst_n(rst_n), .req_valid(v0), .req_write(wr), .req_addr(addr),
        .req_len(len), .req_wdata(wd), .rd_valid(rv0), .rd_data(rd0),
        .map_change(ch0), .sec_bus(sb0));

    cfgsp_regfile #(.HDR_TYPE(8'h01), .REGION_SIZE('0), .REGION_TYPE('0)) dut_br (
        .clk(clk), .rst_n(rst_n), .req_valid(v1), .req_write(wr), .req_addr(addr),
        .req_len(len), .req_wdata(wd), .rd_valid(rv1), .rd_data(rd1),
        .map_change(ch1), .sec_bus(sb1));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input bit br, input bit w, input logic [7:0] bus, input logic [7:0] dfn,
                       input logic [7:0] o, input logic [1:0] l, input logic [31:0] d);
        @(negedge clk);
        wr = w; addr = {bus, dfn, o}; len = l; wd = d;
        if (br) v1 = 1'b1; else v0 = 1'b1;
        @(negedge clk);
        v0 = 1'b0; v1 = 1'b0;
        g_rd = br ? rd1 : rd0;
        g_v  = br ? rv1 : rv0;
        g_ch = br ? ch1 : ch0;
        g_sb = br ? sb1 : sb0;
    endtask

    task automatic rd(input bit br, input logic [7:0] o, input logic [1:0] l);
        acc(br, 1'b0, BUS, DFN, o, l, 32'd0);
    endtask

    task automatic wt(input bit br, input logic [7:0] o, input logic [1:0] l, input logic [31:0] d);
        acc(br, 1'b1, BUS, DFN, o, l, d);
    endtask

    task automatic t_reset;
        check("R1 rd_valid idle", {31'd0, rv0}, 32'd0);
        check("R1 map_change idle", {31'd0, ch0}, 32'd0);
        check("R1 sec_bus", {24'd0, sb1}, 32'd0);
        rd(0, 8'h00, 2'd2); check("R1 id word", g_rd, 32'h1234ABCD);
        check("R2 rd_valid", {31'd0, g_v}, 32'd1);
        rd(0, 8'h08, 2'd2); check("R1 class word", g_rd, 32'h02000001);
        rd(0, 8'h0E, 2'd0); check("R1 header", g_rd, 32'h0);
        rd(1, 8'h0E, 2'd0); check("R1 bridge header", g_rd, 32'h1);
        rd(0, 8'h3D, 2'd0); check("R1 int pin", g_rd, 32'h1);
        rd(0, 8'h10, 2'd2); check("R1 bar0 type", g_rd, 32'h1);
        rd(0, 8'h14, 2'd2); check("R1 bar1 type", g_rd, 32'h8);
        rd(0, 8'h30, 2'd2); check("R1 rom", g_rd, 32'h0);
    endtask

    task automatic t_rw;
        wt(0, 8'h40, 2'd2, 32'hA1B2C3D4);
        check("R12 no strobe plain", {31'd0, g_ch}, 32'd0);
        rd(0, 8'h41, 2'd0); check("R2 byte lane", g_rd, 32'h000000C3);
        rd(0, 8'h42, 2'd1); check("R2 half", g_rd, 32'h0000A1B2);
        rd(0, 8'h40, 2'd3); check("R3 word len3", g_rd, 32'hA1B2C3D4);
        wt(0, 8'hFE, 2'd2, 32'h11223344);
        rd(0, 8'hFE, 2'd1); check("R3 drop past top", g_rd, 32'h00003344);
        rd(0, 8'h00, 2'd0); check("R3 no wrap", g_rd, 32'h000000CD);
    endtask

    task automatic t_fallback;
        rd(0, 8'hFE, 2'd2); check("R4 word->half", g_rd, 32'h00003344);
        rd(0, 8'hFF, 2'd2); check("R4 word->byte", g_rd, 32'h00000033);
        rd(0, 8'hFF, 2'd1); check("R4 half->byte", g_rd, 32'h00000033);
        rd(0, 8'hFC, 2'd2); check("R4 word at FC", g_rd, 32'h33440000);
    endtask

    task automatic t_protect0;
        wt(0, 8'h00, 2'd2, 32'h0);
        rd(0, 8'h00, 2'd2); check("R5 id ro", g_rd, 32'h1234ABCD);
        wt(0, 8'h3D, 2'd0, 32'h7);
        rd(0, 8'h3D, 2'd0); check("R5 int pin ro", g_rd, 32'h1);
        wt(0, 8'h3C, 2'd0, 32'h0B);
        rd(0, 8'h3C, 2'd0); check("R5 int line rw", g_rd, 32'h0B);
        wt(0, 8'h38, 2'd0, 32'h55);
        rd(0, 8'h38, 2'd0); check("R5 0x38 rw", g_rd, 32'h55);
        wt(0, 8'h10, 2'd0, 32'hFF);
        rd(0, 8'h10, 2'd2); check("R5 bar byte ro", g_rd, 32'h1);
        wt(0, 8'h31, 2'd0, 32'hFF);
        rd(0, 8'h30, 2'd2); check("R5 rom byte ro", g_rd, 32'h0);
    endtask

    task automatic t_protect_br;
        wt(1, 8'h10, 2'd0, 32'h5A);
        rd(1, 8'h10, 2'd0); check("R6 bridge 0x10 rw", g_rd, 32'h5A);
        wt(1, 8'h38, 2'd0, 32'h55);
        rd(1, 8'h38, 2'd0); check("R6 bridge 0x38 ro", g_rd, 32'h0);
        wt(1, 8'h02, 2'd1, 32'h0);
        rd(1, 8'h00, 2'd2); check("R6 bridge id ro", g_rd, 32'h1234ABCD);
        wt(1, 8'h30, 2'd2, 32'hCAFE0001);
        rd(1, 8'h30, 2'd2); check("R6 bridge 0x30 rw", g_rd, 32'hCAFE0001);
    endtask

    task automatic t_bar;
        wt(0, 8'h10, 2'd2, 32'hFFFFFFFF);
        check("R12 strobe region", {31'd0, g_ch}, 32'd1);
        rd(0, 8'h10, 2'd2); check("R7 bar0 mask", g_rd, 32'hFFFFFF01);
        wt(0, 8'h14, 2'd2, 32'h12345678);
        rd(0, 8'h14, 2'd2); check("R7 bar1 mask", g_rd, 32'h12345008);
        wt(0, 8'h18, 2'd2, 32'hFFFFFFFF);
        check("R12 no strobe empty region", {31'd0, g_ch}, 32'd0);
        rd(0, 8'h18, 2'd2); check("R7 size0 default path", g_rd, 32'h0);
    endtask

    task automatic t_rom;
        wt(0, 8'h30, 2'd2, 32'hFFFFFFFF);
        rd(0, 8'h30, 2'd2); check("R8 rom mask", g_rd, 32'hFFFFF801);
        wt(0, 8'h30, 2'd2, 32'h12345678);
        rd(0, 8'h30, 2'd2); check("R8 rom enable clear", g_rd, 32'h12345000);
    endtask

    task automatic t_miss;
        acc(0, 0, 8'h03, DFN, 8'h00, 2'd0, 0); check("R9 miss byte", g_rd, 32'hFF);
        check("R9 miss valid", {31'd0, g_v}, 32'd1);
        acc(0, 0, 8'h03, DFN, 8'h00, 2'd1, 0); check("R9 miss half", g_rd, 32'hFFFF);
        acc(0, 0, BUS, 8'h19, 8'h00, 2'd2, 0); check("R9 miss devfn word", g_rd, 32'hFFFFFFFF);
        acc(0, 1, BUS, 8'h20, 8'h40, 2'd2, 32'h0);
        check("R10 miss write no strobe", {31'd0, g_ch}, 32'd0);
        acc(0, 1, 8'h07, DFN, 8'h04, 2'd1, 32'h0);
        check("R10 miss cmd write no strobe", {31'd0, g_ch}, 32'd0);
        rd(0, 8'h40, 2'd2); check("R10 miss write ignored", g_rd, 32'hA1B2C3D4);
    endtask

    task automatic t_secbus;
        wt(1, 8'h19, 2'd0, 32'h05); check("R11 byte 0x19", {24'd0, g_sb}, 32'h05);
        wt(1, 8'h18, 2'd1, 32'h0900); check("R11 half 0x18", {24'd0, g_sb}, 32'h09);
        wt(1, 8'h18, 2'd2, 32'h00000C00); check("R11 word 0x18", {24'd0, g_sb}, 32'h0C);
        wt(1, 8'h18, 2'd0, 32'hFF); check("R11 byte 0x18 none", {24'd0, g_sb}, 32'h0C);
        wt(0, 8'h19, 2'd0, 32'h33); check("R11 type0 none", {24'd0, g_sb}, 32'h00);
    endtask

    task automatic t_strobe;
        wt(0, 8'h04, 2'd1, 32'h0007);
        check("R12 strobe cmd half", {31'd0, g_ch}, 32'd1);
        rd(0, 8'h04, 2'd2); check("R3 cmd stored", g_rd, 32'h00000007);
        check("R12 strobe one cycle", {31'd0, ch0}, 32'd0);
        wt(0, 8'h05, 2'd0, 32'h01); check("R12 strobe byte5", {31'd0, g_ch}, 32'd1);
        wt(0, 8'h06, 2'd0, 32'h01); check("R12 no strobe byte6", {31'd0, g_ch}, 32'd0);
        wt(0, 8'h03, 2'd1, 32'h0000); check("R12 strobe span 3-4", {31'd0, g_ch}, 32'd1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_rw;
        t_fallback;
        t_protect0;
        t_protect_br;
        t_bar;
        t_rom;
        t_miss;
        t_secbus;
        t_strobe;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule